// File: doc/BRIEF.md
# Command-Sequenced SPI Master

This block is an SPI master that runs each frame from one of four command words, taking them in turn. A command word carries everything that shapes a single frame: clock polarity and phase, bit order, frame length, SCK rate, and whether each of three chip-select timing gaps uses its default or a programmable length. The gaps are the lead time from chip-select assertion to the first SCK edge, the trail time from the last SCK edge to chip-select release, and the idle time between releasing chip-select and asserting it again. A sequence-limit input sets the highest command index in use. After each frame the pointer moves to the next index, and it returns to 0 once the limit has been reached.

The surrounding logic presents the four command words on a flat input bus and sets the three delay values. It then pulses `start` once for each frame. The index of the command that drives the current frame, or the next one, is always visible on `cmd_idx`. When a frame ends, `done` pulses and `rx_data` holds the received word, right-aligned.

Top module: `spiseq_master`

## Requirements
- R1: While reset is active and after it is released, `cs_n` is 1, `busy` is 0, `done` is 0 and `cmd_idx` is 0. A reset that arrives mid-frame aborts the frame.
- R2: After each frame the pointer advances by one. When it is at or above `seq_last` it returns to 0 instead, so with `seq_last`=0 it stays at 0. It changes at no other time.
- R3: `cmd_idx` gives the index of the command word used by the current frame. It does not change while `cs_n` stays low.
- R4: The length field (command bits 7:4) selects the frame size. Code 1111 gives 16 bits, 0011 gives 32 bits, and any other code gives 8 bits. A frame has exactly twice as many SCK edges as it has bits.
- R5: Command bit 8 selects bit order. 0 sends and receives MSB first, and 1 sends and receives LSB first.
- R6: Command bit 1 (CPOL) is the SCK level while `cs_n` is high and at chip-select assertion. Command bit 0 (CPHA) selects the sampling edge: 0 samples on odd-numbered edges (1st, 3rd, ...) and 1 samples on even-numbered edges. MOSI changes only between sampling edges.
- R7: Command bits 3:2 (value d) set the SCK period to 2<<d system clocks, with edges evenly spaced at 1<<d clocks.
- R8: The lead time from `cs_n` falling to the first SCK edge is one SCK period when command bit 11 is 0. When bit 11 is 1 it is (`clk_dly`+1) SCK periods.
- R9: The trail time from the last SCK edge to `cs_n` rising is one SCK period when command bit 10 is 0. When bit 10 is 1 it is (`neg_dly`+1) SCK periods.
- R10: With `start` held high, the idle time from `cs_n` rising to the next fall is one SCK period plus 2 clocks when command bit 9 is 0. When bit 9 is 1 it is (`nxt_dly`+1) SCK periods.
- R11: `done` is high for exactly one cycle, in the cycle in which `cs_n` has just risen. At that point `rx_data` holds the bits sampled from `miso`, right-aligned with the upper bits zero.
- R12: A `start` that arrives while `busy` is high is ignored. No second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_table | input | 48 | Four 12-bit command words; word i at bits i*12+11:i*12 |
| seq_last | input | 2 | Highest command index in the sequence |
| clk_dly | input | 3 | Programmable lead delay value |
| neg_dly | input | 3 | Programmable trail delay value |
| nxt_dly | input | 3 | Programmable idle-gap value |
| start | input | 1 | Begin one frame when idle |
| tx_data | input | 32 | Word to transmit, right-aligned |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, 0 when not selected |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Frame or idle gap in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | 32 | Received word |
| cmd_idx | output | 2 | Index of the active command word |

## Verification
The bench runs frames in all four clock modes, both bit orders, every divisor and all three frame sizes, including a length code outside the defined set. It measures lead, edge spacing and trail in clocks, so a counter that is off by one shows up as a timing mismatch, and an edge count tied to the wrong length shows up as the wrong number of edges. Bit order and sampling edge are checked by recording MOSI on the sampling edges, where a reversed order or a shift on the wrong edge produces a scrambled word. Pointer wrap is checked at sequence limits of 3, 1 and 0. The gap between back-to-back frames is checked in both delay modes. A start pulse mid-frame must not produce an extra chip-select, and a reset mid-frame must abort the frame.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
    localparam int CMD_W = 12;

    typedef struct packed {
        logic       lead_en;
        logic       trail_en;
        logic       gap_en;
        logic       lsb_first;
        logic [3:0] len;
        logic [1:0] div;
        logic       cpol;
        logic       cpha;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_GAP
    } st_e;
endpackage

// File: rtl/spiseq_ptr.sv
module spiseq_ptr #(
    parameter int NCMD = 4,
    localparam int IW = $clog2(NCMD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            idx_d = (idx_q >= last) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx_q));
endmodule

// File: rtl/spiseq_engine.sv
module spiseq_engine
    import spiseq_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DLYW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  cmd_t            cmd_in,
    input  logic [DW-1:0]   tx_data,
    input  logic [DLYW-1:0] clk_dly,
    input  logic [DLYW-1:0] neg_dly,
    input  logic [DLYW-1:0] nxt_dly,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            cs_n,
    output logic            busy,
    output logic            done,
    output logic            frame_end,
    output logic [DW-1:0]   rx_data
);
    localparam int CW  = DLYW + 6;
    localparam int BW  = $clog2(2 * DW) + 1;
    localparam int IXW = $clog2(DW);

    typedef struct packed {
        st_e           st;
        cmd_t          cmd;
        logic [CW-1:0] cnt;
        logic [BW-1:0] edges;
        logic [DW-1:0] tx_sr;
        logic [DW-1:0] rx_sr;
        logic [DW-1:0] rx_out;
        logic          sck;
        logic          cs_n;
        logic          done;
    } eng_t;

    eng_t r_d, r_q;

    function automatic logic [BW-1:0] frame_bits(input logic [3:0] code);
        case (code)
            4'b1111: return BW'(16);
            4'b0011: return BW'(32);
            default: return BW'(8);
        endcase
    endfunction

    function automatic logic [CW-1:0] sck_period(input logic [1:0] dv);
        return CW'(2) << dv;
    endfunction

    function automatic logic [CW-1:0] span(input logic en, input logic [DLYW-1:0] n,
                                           input logic [1:0] dv);
        return en ? (CW'(n) + CW'(1)) * sck_period(dv) : sck_period(dv);
    endfunction

    logic [BW-1:0] nb;
    logic [BW-1:0] e;
    logic [CW-1:0] half;
    logic          is_last;
    logic          samp;
    logic          shft;
    logic          tx_bit;

    always_comb begin
        nb      = frame_bits(r_q.cmd.len);
        e       = r_q.edges;
        half    = sck_period(r_q.cmd.div) >> 1;
        is_last = (e == (nb << 1) - BW'(1));
        samp    = r_q.cmd.cpha ? e[0] : ~e[0];
        shft    = ~samp & (r_q.cmd.cpha ? (e != '0) : ~is_last);
        tx_bit  = r_q.cmd.lsb_first ? r_q.tx_sr[0] : r_q.tx_sr[IXW'(nb - BW'(1))];
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.sck = cmd_in.cpol;
                if (start) begin
                    r_d.st    = ST_LEAD;
                    r_d.cmd   = cmd_in;
                    r_d.cs_n  = 1'b0;
                    r_d.cnt   = span(cmd_in.lead_en, clk_dly, cmd_in.div) - CW'(1);
                    r_d.tx_sr = tx_data;
                    r_d.rx_sr = '0;
                    r_d.edges = '0;
                end
            end
            ST_LEAD, ST_XFER: begin
                if (r_q.cnt == '0) begin
                    r_d.sck   = ~r_q.sck;
                    r_d.edges = e + BW'(1);
                    if (samp) begin
                        r_d.rx_sr = r_q.cmd.lsb_first ? {miso, r_q.rx_sr[DW-1:1]}
                                                      : {r_q.rx_sr[DW-2:0], miso};
                    end
                    if (shft) begin
                        r_d.tx_sr = r_q.cmd.lsb_first ? (r_q.tx_sr >> 1) : (r_q.tx_sr << 1);
                    end
                    if (is_last) begin
                        r_d.st  = ST_TRAIL;
                        r_d.cnt = span(r_q.cmd.trail_en, neg_dly, r_q.cmd.div) - CW'(1);
                    end else begin
                        r_d.st  = ST_XFER;
                        r_d.cnt = half - CW'(1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_TRAIL: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_GAP;
                    r_d.cs_n   = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.rx_out = r_q.cmd.lsb_first ? (r_q.rx_sr >> (BW'(DW) - nb)) : r_q.rx_sr;
                    r_d.cnt    = r_q.cmd.gap_en
                               ? span(1'b1, nxt_dly, r_q.cmd.div) - CW'(2)
                               : sck_period(r_q.cmd.div);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_GAP: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - CW'(1);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck       = r_q.sck;
    assign cs_n      = r_q.cs_n;
    assign mosi      = r_q.cs_n ? 1'b0 : tx_bit;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign rx_data   = r_q.rx_out;
    assign frame_end = (r_q.st == ST_TRAIL) && (r_q.cnt == '0);

    // R11
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    // R11
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.cs_n && !$past(r_q.cs_n)));
    // R4
    xfer_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_XFER) |-> !r_q.cs_n);
    // R3
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.cs_n && !$past(r_q.cs_n)) |-> $stable(r_q.cmd));
endmodule

// File: rtl/spiseq_master.sv
module spiseq_master
    import spiseq_pkg::*;
#(
    parameter int NCMD = 4,
    parameter int DW   = 32,
    parameter int DLYW = 3,
    localparam int IW  = $clog2(NCMD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCMD*CMD_W-1:0] cmd_table,
    input  logic [IW-1:0]         seq_last,
    input  logic [DLYW-1:0]       clk_dly,
    input  logic [DLYW-1:0]       neg_dly,
    input  logic [DLYW-1:0]       nxt_dly,
    input  logic                  start,
    input  logic [DW-1:0]         tx_data,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic                  cs_n,
    output logic                  busy,
    output logic                  done,
    output logic [DW-1:0]         rx_data,
    output logic [IW-1:0]         cmd_idx
);
    cmd_t tbl [NCMD];
    cmd_t cur_cmd;
    logic adv;

    for (genvar g = 0; g < NCMD; g++) begin : g_slot
        assign tbl[g] = cmd_t'(cmd_table[g*CMD_W +: CMD_W]);
    end

    assign cur_cmd = tbl[cmd_idx];

    spiseq_ptr #(.NCMD(NCMD)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .last (seq_last),
        .idx  (cmd_idx)
    );

    spiseq_engine #(.DW(DW), .DLYW(DLYW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd_in   (cur_cmd),
        .tx_data  (tx_data),
        .clk_dly  (clk_dly),
        .neg_dly  (neg_dly),
        .nxt_dly  (nxt_dly),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .busy     (busy),
        .done     (done),
        .frame_end(adv),
        .rx_data  (rx_data)
    );

    // R3
    idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(cmd_idx));
endmodule

// File: tb/tb_spiseq_master.sv
module tb_spiseq_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] cmd_table = '0;
    logic [1:0]  seq_last = 2'd3;
    logic [2:0]  clk_dly = 3'd2;
    logic [2:0]  neg_dly = 3'd1;
    logic [2:0]  nxt_dly = 3'd3;
    logic        start = 1'b0;
    logic [31:0] tx_data = '0;
    logic        loop = 1'b1;
    logic        miso_val = 1'b0;
    logic        miso;
    logic        sck, mosi, cs_n, busy, done;
    logic [31:0] rx_data;
    logic [1:0]  cmd_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign miso = loop ? mosi : miso_val;

    always #4 clk = ~clk;

    spiseq_master dut (
        .clk(clk), .rst_n(rst_n), .cmd_table(cmd_table), .seq_last(seq_last),
        .clk_dly(clk_dly), .neg_dly(neg_dly), .nxt_dly(nxt_dly), .start(start),
        .tx_data(tx_data), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .busy(busy), .done(done), .rx_data(rx_data), .cmd_idx(cmd_idx)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // observation of the serial side, sampled mid-cycle
    logic        prev_cs = 1'b1, prev_sck = 1'b0, cur_cpha = 1'b0;
    int          n_falls = 0, n_done = 0, n_edges = 0;
    int          t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, t_done = 0, gap_meas = 0;
    int          min_sp = 0, max_sp = 0;
    logic        sck_at_fall = 1'b0;
    logic [1:0]  idx_at_fall = '0;
    logic [31:0] cap = '0;

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            t_fall = cyc; gap_meas = cyc - t_rise; sck_at_fall = sck;
            idx_at_fall = cmd_idx; n_edges = 0; cap = '0;
            min_sp = 1000; max_sp = 0; n_falls++;
        end
        if (!cs_n && (sck != prev_sck)) begin
            if (n_edges == 0) t_first = cyc;
            else begin
                if (cyc - t_last < min_sp) min_sp = cyc - t_last;
                if (cyc - t_last > max_sp) max_sp = cyc - t_last;
            end
            t_last = cyc;
            if ((n_edges % 2) == (cur_cpha ? 1 : 0)) cap = {cap[30:0], mosi};
            n_edges++;
        end
        if (!prev_cs && cs_n) t_rise = cyc;
        if (done) begin n_done++; t_done = cyc; end
        prev_cs = cs_n;
        prev_sck = sck;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int f_bits(input logic [3:0] code);
        if (code == 4'b1111) return 16;
        if (code == 4'b0011) return 32;
        return 8;
    endfunction

    function automatic int f_per(input logic [1:0] d);
        return 2 << d;
    endfunction

    function automatic longint f_mask(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic longint f_rev(input logic [31:0] d, input int n);
        logic [31:0] o = '0;
        for (int i = 0; i < n; i++) o[n-1-i] = d[i];
        return longint'(o);
    endfunction

    task automatic tick;
        @(posedge clk); #2;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; start = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wait_idle;
        while (busy) tick();
    endtask

    task automatic run_frame(input logic [11:0] c, input logic [31:0] dat, input int exp_idx);
        int d0, f0, n, p;
        longint exp_cap;
        cmd_table[exp_idx*12 +: 12] = c;
        cur_cpha = c[0];
        tx_data = dat;
        tick(); tick();
        d0 = n_done; f0 = n_falls;
        start = 1'b1; tick(); start = 1'b0;
        while (n_done == d0) tick();
        check("R11 done width", done, 0);
        wait_idle();
        n = f_bits(c[7:4]);
        p = f_per(c[3:2]);
        exp_cap = c[8] ? f_rev(dat, n) : (longint'(dat) & f_mask(n));
        check("R3 index", idx_at_fall, exp_idx);
        check("R6 idle level", sck_at_fall, c[1]);
        check("R8 lead", t_first - t_fall, c[11] ? (clk_dly + 1) * p : p);
        check("R4 edges", n_edges, 2 * n);
        check("R7 min spacing", min_sp, p / 2);
        check("R7 max spacing", max_sp, p / 2);
        check("R9 trail", t_rise - t_last, c[10] ? (neg_dly + 1) * p : p);
        check("R5 R6 mosi order", cap, exp_cap);
        if (loop) check("R11 rx word", rx_data, longint'(dat) & f_mask(n));
        check("R11 done count", n_done - d0, 1);
        check("R11 done with release", t_done, t_rise);
        check("R12 one select", n_falls - f0, 1);
    endtask

    task automatic run_gap(input logic [11:0] c, input int exp_gap);
        int f0;
        do_reset();
        seq_last = 2'd0;
        cmd_table[11:0] = c;
        cur_cpha = c[0];
        tx_data = 32'h5A;
        tick();
        f0 = n_falls;
        start = 1'b1;
        while (n_falls < f0 + 2) tick();
        start = 1'b0;
        tick();
        wait_idle();
        check("R10 gap", gap_meas, exp_gap);
        check("R2 limit zero", cmd_idx, 0);
    endtask

    // stimulus: {command word, transmit word}
    localparam logic [43:0] VEC [6] = '{
        {12'h070, 32'h0000_00A5},
        {12'h1F6, 32'h0000_1234},
        {12'h831, 32'hDEAD_BEEF},
        {12'h54B, 32'h0000_003C},
        {12'hC0C, 32'h0000_0081},
        {12'h151, 32'h0000_0096}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0, d0;
        repeat (2) tick();
        check("R1 cs during reset", cs_n, 1);
        check("R1 busy during reset", busy, 0);
        rst_n = 1'b1;
        tick();
        check("R1 cs", cs_n, 1);
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 index", cmd_idx, 0);

        // vector walk, sequence limit 3, loopback receive
        seq_last = 2'd3;
        for (int i = 0; i < 6; i++) begin
            run_frame(VEC[i][43:32], VEC[i][31:0], i % 4);
        end
        check("R2 wrap position", cmd_idx, 2);

        // R6 idle level follows the selected command's CPOL
        cmd_table[2*12 +: 12] = 12'h072;
        repeat (2) tick();
        check("R6 idle high", sck, 1);

        // R2 limit of 1: indices 0,1,0
        do_reset();
        seq_last = 2'd1;
        run_frame(12'h070, 32'h11, 0);
        run_frame(12'h071, 32'h22, 1);
        run_frame(12'h072, 32'h33, 0);

        // R11 receive from a fixed miso level
        do_reset();
        loop = 1'b0; miso_val = 1'b1;
        run_frame(12'h0F0, 32'h0, 0);
        check("R11 rx ones 16", rx_data, 32'h0000_FFFF);
        run_frame(12'h140, 32'h0, 1);
        check("R11 rx ones lsb 8", rx_data, 32'h0000_00FF);
        loop = 1'b1;

        // R10 idle gap, default and programmed
        run_gap(12'h070, 4);
        run_gap(12'h270, 8);
        run_gap(12'h274, 16);

        // R12 start while busy
        do_reset();
        seq_last = 2'd3;
        cmd_table[11:0] = 12'h074;
        cur_cpha = 1'b0;
        tick();
        f0 = n_falls; d0 = n_done;
        start = 1'b1; tick(); start = 1'b0;
        repeat (10) tick();
        start = 1'b1; tick(); start = 1'b0;
        repeat (300) tick();
        check("R12 selects", n_falls - f0, 1);
        check("R12 done pulses", n_done - d0, 1);
        check("R12 idle after", busy, 0);

        // R1 reset mid-frame
        start = 1'b1; tick(); start = 1'b0;
        repeat (6) tick();
        rst_n = 1'b0;
        tick();
        check("R1 abort cs", cs_n, 1);
        check("R1 abort busy", busy, 0);
        rst_n = 1'b1;
        tick();
        check("R1 abort index", cmd_idx, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule